// File: doc/BRIEF.md
# Receive DMA Descriptor-Chain Controller

This block takes received Ethernet frames out of a receive FIFO and writes them to memory. Where each frame goes is given by a linked chain of four-word descriptors in memory. Software first sets a first-descriptor pointer and then sets the channel enable bit. The block then reads the descriptor through a single-outstanding memory request port and checks that hardware owns it. It then pops FIFO words and writes each one to the buffer, advancing four bytes per word.

At the end of each frame the enable bit drops. It comes back by itself when the finished descriptor does not mark the end of the chain. A separate stop bit lets the current frame finish and then keeps later frames waiting in the FIFO until software clears it. A pause-request output asks the transmit side for flow control after a FIFO overrun.

The state machine has ten states:
- IDLE waits for the enable bit.
- FETCH_REQ and FETCH_WAIT read the four descriptor words.
- CHECK tests the ownership bit.
- XFER pops one FIFO word.
- WR_REQ and WR_WAIT write that word to memory.
- DRAIN discards the rest of a frame that is too long.
- FRAME_END records the result.
- CHAIN decides whether to fetch the next descriptor.

Its transitions are:
- IDLE to FETCH_REQ on enable with stop clear.
- FETCH_REQ to FETCH_WAIT on request accept.
- FETCH_WAIT back to FETCH_REQ for the next word, to CHECK after the fourth word, or to IDLE on an error response.
- CHECK back to FETCH_REQ when software owns the descriptor, otherwise to XFER.
- XFER to WR_REQ on a pop, or to DRAIN when the buffer is full.
- WR_REQ to WR_WAIT on accept.
- WR_WAIT back to XFER, or to FRAME_END after the last word.
- DRAIN to FRAME_END once the last word is discarded.
- FRAME_END to CHAIN.
- CHAIN to FETCH_REQ when chaining, otherwise to IDLE.

Top module: `rxdma_chain_ctrl`

## Requirements
- R1: After reset the control register (offset 0x200; bit 0 enable, bit 1 flow-control, bit 2 little-endian) reads 0x4. The status register (0x204), stop register (0x208) and `pause_req` are all 0.
- R2: A write to the control register or to the first-descriptor pointer register (0x20C) while the enable bit is 1 leaves that register unchanged.
- R3: Writing enable=1 reads four descriptor words at pointer+0, +4, +8 and +12. These are buffer address, buffer length in words, next pointer and flags. FIFO word i of the frame is then written to buffer+4*i. Enable reads 1 from fetch through transfer.
- R4: Once the write response for the frame's last word arrives, the enable bit clears. Status bit 0 (frame done) sets, and status bits 31:16 hold the number of words written.
- R5: When flags bit 0 (end of chain) is 0, enable stays 0 for exactly one cycle and then returns to 1, and the descriptor at the next pointer is fetched. When the bit is 1, the channel stays idle.
- R6: An error response to a descriptor read clears enable and sets status bit 1. That bit stays set until cleared.
- R7: Stop register bit 0 takes effect at a frame boundary. Later frames are not popped from the FIFO while it is 1. After it is cleared, a new enable starts the next frame.
- R8: With flow control on and `full_duplex` high, a `fifo_overrun` pulse raises `pause_req`. It stays high until `fifo_empty` is seen. Without full duplex, an overrun raises nothing.
- R9: A descriptor whose flags bit 31 is 0 (owned by software) is re-read until that bit becomes 1. No FIFO word is popped in the meantime.
- R10: A frame longer than the buffer length is cut to that length and status bit 2 is set. Its remaining FIFO words are popped and discarded.
- R11: With the little-endian bit 0, each data word is byte-reversed before it is written.
- R12: Writing 1 to status bits 0, 1 or 2 clears that bit.
- R13: A memory request holds its valid, address and direction until ready is seen. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_err | input | 1 | Memory response error |
| mem_rsp_rdata | input | 32 | Memory read data |
| fifo_valid | input | 1 | FIFO has a word |
| fifo_data | input | 32 | FIFO head word |
| fifo_last | input | 1 | Head word ends a frame |
| fifo_ready | output | 1 | Pop FIFO head |
| fifo_empty | input | 1 | FIFO empty |
| fifo_overrun | input | 1 | FIFO overrun pulse |
| full_duplex | input | 1 | Link is full duplex |
| pause_req | output | 1 | Pause request to transmit side |

## Verification
The assertions check the following on every cycle:
- a stalled memory request holds steady;
- the enable bit stays high in every busy state;
- no data write targets a word beyond the buffer length;
- a blocked control write leaves the register alone;
- a descriptor error lands as a sticky bit with enable low;
- the pause request only rises on a qualified overrun and holds until the FIFO empties.

Other behaviour only the bench's scenarios can show:
- the exact one-cycle enable dip between chained frames;
- the byte order of written data;
- truncation with draining;
- polling of a descriptor owned by software;
- frames held back by the stop bit and released after restart.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    localparam logic [11:0] OFS_CTRL = 12'h200;
    localparam logic [11:0] OFS_STAT = 12'h204;
    localparam logic [11:0] OFS_STOP = 12'h208;
    localparam logic [11:0] OFS_DPTR = 12'h20C;

    localparam int CTL_EN  = 0;
    localparam int CTL_FL  = 1;
    localparam int CTL_LE  = 2;
    localparam int ST_DONE = 0;
    localparam int ST_DERR = 1;
    localparam int ST_OVF  = 2;
    localparam int ST_CNT  = 16;
    localparam int FLG_EOC = 0;
    localparam int FLG_OWN = 31;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH_REQ, S_FETCH_WAIT, S_CHECK, S_XFER,
        S_WR_REQ, S_WR_WAIT, S_DRAIN, S_FRAME_END, S_CHAIN
    } rx_state_e;
endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              en_o,
    output logic              fl_o,
    output logic              le_o,
    output logic              stop_o,
    output logic [ADDR_W-1:0] dptr_o,
    input  logic              hw_en_clr,
    input  logic              hw_en_set,
    input  logic              hw_done,
    input  logic [LEN_W-1:0]  hw_count,
    input  logic              hw_desc_err,
    input  logic              hw_len_ovf
);
    logic              en_q, fl_q, le_q, stop_q;
    logic              done_q, derr_q, ovf_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] dptr_q;
    logic              ctrl_wr, dptr_wr, stat_wr;

    assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL) && !en_q;
    assign dptr_wr = reg_wr && (reg_addr == OFS_DPTR) && !en_q;
    assign stat_wr = reg_wr && (reg_addr == OFS_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            fl_q   <= 1'b0;
            le_q   <= 1'b1;
            stop_q <= 1'b0;
            dptr_q <= '0;
            done_q <= 1'b0;
            derr_q <= 1'b0;
            ovf_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q <= reg_wdata[CTL_EN];
                fl_q <= reg_wdata[CTL_FL];
                le_q <= reg_wdata[CTL_LE];
            end
            if (hw_en_clr) en_q <= 1'b0;
            if (hw_en_set) en_q <= 1'b1;
            if (dptr_wr) dptr_q <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && (reg_addr == OFS_STOP)) stop_q <= reg_wdata[0];
            if (stat_wr) begin
                done_q <= done_q & ~reg_wdata[ST_DONE];
                derr_q <= derr_q & ~reg_wdata[ST_DERR];
                ovf_q  <= ovf_q  & ~reg_wdata[ST_OVF];
            end
            if (hw_done) begin
                done_q <= 1'b1;
                cnt_q  <= hw_count;
            end
            if (hw_desc_err) derr_q <= 1'b1;
            if (hw_len_ovf)  ovf_q  <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTL_EN] = en_q;
                reg_rdata[CTL_FL] = fl_q;
                reg_rdata[CTL_LE] = le_q;
            end
            OFS_STAT: begin
                reg_rdata[ST_DONE]            = done_q;
                reg_rdata[ST_DERR]            = derr_q;
                reg_rdata[ST_OVF]             = ovf_q;
                reg_rdata[ST_CNT +: LEN_W]    = cnt_q;
            end
            OFS_STOP: reg_rdata[0] = stop_q;
            OFS_DPTR: reg_rdata[ADDR_W-1:0] = dptr_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign en_o   = en_q;
    assign fl_o   = fl_q;
    assign le_o   = le_q;
    assign stop_o = stop_q;
    assign dptr_o = dptr_q;

    // R2
    ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CTRL && en_q) |=> ($stable(fl_q) && $stable(le_q)));
    // R2
    dptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DPTR && en_q) |=> $stable(dptr_q));
    // R6
    desc_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_desc_err |=> (derr_q && !en_q));
endmodule

// File: rtl/rxdma_pause.sv
module rxdma_pause (
    input  logic clk,
    input  logic rst_n,
    input  logic fl_en,
    input  logic full_duplex,
    input  logic fifo_overrun,
    input  logic fifo_empty,
    output logic pause_req
);
    logic pause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   pause_q <= 1'b0;
        else if (fl_en && full_duplex && fifo_overrun) pause_q <= 1'b1;
        else if (fifo_empty)                          pause_q <= 1'b0;
    end

    assign pause_req = pause_q;

    // R8
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_q && !fifo_empty) |=> pause_q);
    // R8
    pause_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_q) |-> $past(fl_en && full_duplex && fifo_overrun));
endmodule

// File: rtl/rxdma_fsm.sv
module rxdma_fsm
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              le,
    input  logic              stop,
    input  logic [ADDR_W-1:0] dptr,
    output logic              hw_en_clr,
    output logic              hw_en_set,
    output logic              hw_done,
    output logic [LEN_W-1:0]  hw_count,
    output logic              hw_desc_err,
    output logic              hw_len_ovf,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_last,
    output logic              fifo_ready
);
    localparam int NBYTES = DATA_W / 8;

    rx_state_e         state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, buf_q, next_q;
    logic [LEN_W-1:0]  len_q, wcnt_q;
    logic [DATA_W-1:0] flags_q, data_q, data_sw;
    logic [1:0]        widx_q;
    logic              last_q;
    logic              buf_full, chain_go;

    assign buf_full = (wcnt_q == len_q);
    assign chain_go = !flags_q[FLG_EOC] && !stop;

    for (genvar g = 0; g < NBYTES; g++) begin : g_swap
        assign data_sw[8*g +: 8] = le ? data_q[8*g +: 8] : data_q[DATA_W-8-8*g +: 8];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (en && !stop) state_d = S_FETCH_REQ;
            S_FETCH_REQ:  if (mem_req_ready) state_d = S_FETCH_WAIT;
            S_FETCH_WAIT: if (mem_rsp_valid) begin
                              if (mem_rsp_err)      state_d = S_IDLE;
                              else if (widx_q == 2'd3) state_d = S_CHECK;
                              else                  state_d = S_FETCH_REQ;
                          end
            S_CHECK:      state_d = flags_q[FLG_OWN] ? S_XFER : S_FETCH_REQ;
            S_XFER:       if (fifo_valid) state_d = buf_full ? S_DRAIN : S_WR_REQ;
            S_WR_REQ:     if (mem_req_ready) state_d = S_WR_WAIT;
            S_WR_WAIT:    if (mem_rsp_valid) state_d = last_q ? S_FRAME_END : S_XFER;
            S_DRAIN:      if (fifo_valid && fifo_last) state_d = S_FRAME_END;
            S_FRAME_END:  state_d = S_CHAIN;
            S_CHAIN:      state_d = chain_go ? S_FETCH_REQ : S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            buf_q   <= '0;
            next_q  <= '0;
            len_q   <= '0;
            flags_q <= '0;
            wcnt_q  <= '0;
            widx_q  <= '0;
            data_q  <= '0;
            last_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    ptr_q  <= dptr;
                    widx_q <= '0;
                end
                S_FETCH_WAIT: if (mem_rsp_valid && !mem_rsp_err) begin
                    unique case (widx_q)
                        2'd0: buf_q   <= mem_rsp_rdata[ADDR_W-1:0];
                        2'd1: len_q   <= mem_rsp_rdata[LEN_W-1:0];
                        2'd2: next_q  <= mem_rsp_rdata[ADDR_W-1:0];
                        2'd3: flags_q <= mem_rsp_rdata;
                        default: ;
                    endcase
                    widx_q <= widx_q + 2'd1;
                end
                S_CHECK: begin
                    widx_q <= '0;
                    wcnt_q <= '0;
                end
                S_XFER: if (fifo_valid && !buf_full) begin
                    data_q <= fifo_data;
                    last_q <= fifo_last;
                end
                S_WR_WAIT: if (mem_rsp_valid) wcnt_q <= wcnt_q + 1'b1;
                S_CHAIN: if (chain_go) begin
                    ptr_q  <= next_q;
                    widx_q <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = ptr_q + (ADDR_W'(widx_q) << 2);
        mem_req_wdata = data_sw;
        fifo_ready    = 1'b0;
        hw_en_clr     = 1'b0;
        hw_en_set     = 1'b0;
        hw_done       = 1'b0;
        hw_desc_err   = 1'b0;
        hw_len_ovf    = 1'b0;
        hw_count      = wcnt_q;
        unique case (state_q)
            S_FETCH_REQ:  mem_req_valid = 1'b1;
            S_FETCH_WAIT: if (mem_rsp_valid && mem_rsp_err) begin
                              hw_en_clr   = 1'b1;
                              hw_desc_err = 1'b1;
                          end
            S_XFER: begin
                fifo_ready = fifo_valid && !buf_full;
                hw_len_ovf = fifo_valid && buf_full;
            end
            S_WR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = buf_q + (ADDR_W'(wcnt_q) << 2);
            end
            S_DRAIN:      fifo_ready = fifo_valid;
            S_FRAME_END: begin
                hw_done   = 1'b1;
                hw_en_clr = 1'b1;
            end
            S_CHAIN:      hw_en_set = chain_go;
            default: ;
        endcase
    end

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
    // R3
    en_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && state_q != S_CHAIN) |-> en);
    // R10
    wr_in_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (wcnt_q < len_q));
endmodule

// File: rtl/rxdma_chain_ctrl.sv
module rxdma_chain_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_last,
    output logic              fifo_ready,
    input  logic              fifo_empty,
    input  logic              fifo_overrun,
    input  logic              full_duplex,
    output logic              pause_req
);
    logic              en, fl, le, stop;
    logic [ADDR_W-1:0] dptr;
    logic              hw_en_clr, hw_en_set, hw_done, hw_desc_err, hw_len_ovf;
    logic [LEN_W-1:0]  hw_count;

    rxdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .en_o(en), .fl_o(fl), .le_o(le), .stop_o(stop), .dptr_o(dptr),
        .hw_en_clr(hw_en_clr), .hw_en_set(hw_en_set), .hw_done(hw_done),
        .hw_count(hw_count), .hw_desc_err(hw_desc_err), .hw_len_ovf(hw_len_ovf)
    );

    rxdma_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en(en), .le(le), .stop(stop), .dptr(dptr),
        .hw_en_clr(hw_en_clr), .hw_en_set(hw_en_set), .hw_done(hw_done),
        .hw_count(hw_count), .hw_desc_err(hw_desc_err), .hw_len_ovf(hw_len_ovf),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
        .fifo_ready(fifo_ready)
    );

    rxdma_pause u_pause (
        .clk(clk), .rst_n(rst_n), .fl_en(fl), .full_duplex(full_duplex),
        .fifo_overrun(fifo_overrun), .fifo_empty(fifo_empty), .pause_req(pause_req)
    );
endmodule

// File: tb/test_rxdma_chain_ctrl.sv
module test_rxdma_chain_ctrl;
    localparam logic [11:0] A_CTRL = 12'h200, A_STAT = 12'h204, A_STOP = 12'h208, A_DPTR = 12'h20C;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0;
    logic [11:0] reg_addr = A_CTRL;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mem_req_valid, mem_req_write, fifo_ready, pause_req;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic ready_en = 1, mem_rsp_valid = 0, mem_rsp_err = 0;
    logic [31:0] mem_rsp_rdata = 0, err_addr = 32'hFFFF_FFFF;
    logic fifo_overrun = 0, full_duplex = 0;
    logic [31:0] mem [0:255];
    logic [31:0] fq [0:63];
    logic        fql [0:63];
    int rd_idx = 0, wr_idx = 0;
    int n_tests = 0, n_fail = 0, en_falls = 0;
    logic en_prev = 0;
    logic fifo_valid, fifo_last, fifo_empty;
    logic [31:0] fifo_data;

    assign fifo_valid = rd_idx < wr_idx;
    assign fifo_empty = !fifo_valid;
    assign fifo_data  = fq[rd_idx % 64];
    assign fifo_last  = fql[rd_idx % 64];

    always #2.5 clk = ~clk;

    rxdma_chain_ctrl i_rxdma_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(ready_en),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
        .fifo_ready(fifo_ready), .fifo_empty(fifo_empty), .fifo_overrun(fifo_overrun),
        .full_duplex(full_duplex), .pause_req(pause_req)
    );

    // memory model: one-cycle response
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (mem_req_valid && ready_en) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_rdata <= mem[mem_req_addr[9:2]];
            mem_rsp_err   <= !mem_req_write && (mem_req_addr == err_addr);
            if (mem_req_write) mem[mem_req_addr[9:2]] <= mem_req_wdata;
        end
        if (fifo_valid && fifo_ready) rd_idx <= rd_idx + 1;
    end

    always @(negedge clk) begin
        if (reg_addr == A_CTRL && !reg_wr) begin
            if (en_prev && !reg_rdata[0]) en_falls++;
            en_prev <= reg_rdata[0];
        end
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_addr = A_CTRL;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = A_CTRL;
    endtask

    task automatic put_desc(input logic [31:0] at, bufa, len, nxt, flg);
        mem[at[9:2]] = bufa; mem[at[9:2]+1] = len;
        mem[at[9:2]+2] = nxt; mem[at[9:2]+3] = flg;
    endtask

    task automatic push(input logic [31:0] w, input logic l);
        fq[wr_idx % 64] = w; fql[wr_idx % 64] = l;
        wr_idx++;
    endtask

    task automatic wait_done();
        int t = 0;
        while (rd_idx != wr_idx && t < 2000) begin cyc(1); t++; end
        cyc(12);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h4);
        rd(A_STAT, v); chk("R1 stat", v, 32'h0);
        rd(A_STOP, v); chk("R1 stop", v, 32'h0);
        chk("R1 pause", {31'b0, pause_req}, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v, a0;
        put_desc(32'h100, 32'h200, 8, 0, 32'h8000_0001);
        ready_en = 0;
        wr(A_DPTR, 32'h100);
        wr(A_CTRL, 32'h5);
        cyc(3);
        chk("R13 stall valid", {31'b0, mem_req_valid}, 32'h1);
        a0 = mem_req_addr;
        chk("R3 first fetch addr", a0, 32'h100);
        cyc(4);
        chk("R13 stall held", {mem_req_valid, mem_req_addr[30:0]}, {1'b1, a0[30:0]});
        ready_en = 1;
        cyc(15);
        rd(A_CTRL, v); chk("R3 en busy", v, 32'h5);
        wr(A_CTRL, 32'h2);
        wr(A_DPTR, 32'h40);
        rd(A_CTRL, v); chk("R2 ctrl locked", v, 32'h5);
        rd(A_DPTR, v); chk("R2 dptr locked", v, 32'h100);
        push(32'hA0A0_0001, 0); push(32'hA0A0_0002, 0); push(32'hA0A0_0003, 1);
        wait_done();
        chk("R3 word0", mem[128], 32'hA0A0_0001);
        chk("R3 word2", mem[130], 32'hA0A0_0003);
        rd(A_STAT, v); chk("R4 status", v, 32'h0003_0001);
        cyc(10);
        rd(A_CTRL, v); chk("R5 eoc idle", v, 32'h4);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk("R12 done clear", v, 32'h0003_0000);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        put_desc(32'h100, 32'h200, 8, 32'h140, 32'h8000_0000);
        put_desc(32'h140, 32'h300, 8, 0, 32'h8000_0001);
        push(32'hB1, 0); push(32'hB2, 1); push(32'hC1, 1);
        wr(A_DPTR, 32'h100);
        en_falls = 0;
        wr(A_CTRL, 32'h5);
        wait_done();
        chk("R5 frame A", mem[129], 32'hB2);
        chk("R5 frame B", mem[192], 32'hC1);
        chk("R5 en dips", en_falls, 2);
        rd(A_STAT, v); chk("R4 count B", v & 32'hFFFF_0001, 32'h0001_0001);
    endtask

    task automatic t_own();
        logic [31:0] v;
        put_desc(32'h100, 32'h200, 8, 0, 32'h0000_0001);
        mem[128] = 0;
        push(32'hD00D, 1);
        wr(A_CTRL, 32'h5);
        cyc(40);
        rd(A_CTRL, v); chk("R9 still busy", v, 32'h5);
        chk("R9 no pop", wr_idx - rd_idx, 1);
        chk("R9 no write", mem[128], 32'h0);
        mem[67] = 32'h8000_0001;
        wait_done();
        chk("R9 written after own", mem[128], 32'hD00D);
    endtask

    task automatic t_err();
        logic [31:0] v;
        wr(A_STAT, 32'h7);
        put_desc(32'h100, 32'h200, 8, 0, 32'h8000_0001);
        err_addr = 32'h108;
        wr(A_CTRL, 32'h5);
        cyc(20);
        rd(A_CTRL, v); chk("R6 en off", v, 32'h4);
        rd(A_STAT, v); chk("R6 desc err", v & 32'h7, 32'h2);
        cyc(5);
        rd(A_STAT, v); chk("R6 sticky", v & 32'h7, 32'h2);
        wr(A_STAT, 32'h2);
        rd(A_STAT, v); chk("R12 derr clear", v & 32'h7, 32'h0);
        err_addr = 32'hFFFF_FFFF;
    endtask

    task automatic t_trunc();
        logic [31:0] v;
        put_desc(32'h100, 32'h200, 2, 0, 32'h8000_0001);
        mem[130] = 32'hDEAD;
        push(32'hE1, 0); push(32'hE2, 0); push(32'hE3, 0); push(32'hE4, 1);
        wr(A_CTRL, 32'h5);
        wait_done();
        chk("R10 word1", mem[129], 32'hE2);
        chk("R10 no spill", mem[130], 32'hDEAD);
        chk("R10 drained", wr_idx - rd_idx, 0);
        rd(A_STAT, v); chk("R10 status", v & 32'hFFFF_0007, 32'h0002_0005);
        wr(A_STAT, 32'h7);
    endtask

    task automatic t_endian();
        put_desc(32'h100, 32'h200, 8, 0, 32'h8000_0001);
        push(32'h1122_3344, 1);
        wr(A_CTRL, 32'h1);
        wait_done();
        chk("R11 swapped", mem[128], 32'h4433_2211);
        wr(A_CTRL, 32'h4);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        put_desc(32'h100, 32'h200, 8, 32'h140, 32'h8000_0000);
        put_desc(32'h140, 32'h300, 8, 0, 32'h8000_0001);
        mem[192] = 0;
        wr(A_DPTR, 32'h100);
        wr(A_CTRL, 32'h5);
        cyc(15);
        wr(A_STOP, 32'h1);
        push(32'hF1, 1); push(32'hF2, 1);
        cyc(30);
        chk("R7 frame1 done", mem[128], 32'hF1);
        rd(A_CTRL, v); chk("R7 halted", v, 32'h4);
        chk("R7 frame2 held", wr_idx - rd_idx, 1);
        chk("R7 no write B", mem[192], 32'h0);
        wr(A_STOP, 32'h0);
        wr(A_DPTR, 32'h140);
        wr(A_CTRL, 32'h5);
        wait_done();
        chk("R7 restart", mem[192], 32'hF2);
    endtask

    task automatic t_pause();
        wr(A_CTRL, 32'h6);
        full_duplex = 1;
        push(32'h1, 0); push(32'h2, 0);
        @(negedge clk) fifo_overrun = 1;
        @(negedge clk) fifo_overrun = 0;
        chk("R8 pause set", {31'b0, pause_req}, 32'h1);
        cyc(5);
        chk("R8 pause held", {31'b0, pause_req}, 32'h1);
        wr_idx = rd_idx;
        cyc(2);
        chk("R8 pause clear", {31'b0, pause_req}, 32'h0);
        full_duplex = 0;
        push(32'h3, 0);
        @(negedge clk) fifo_overrun = 1;
        @(negedge clk) fifo_overrun = 0;
        chk("R8 half duplex", {31'b0, pause_req}, 32'h0);
        wr_idx = rd_idx;
        wr(A_CTRL, 32'h4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 0;
        cyc(4);
        rst_n = 1;
        cyc(2);
        t_reset();
        t_single();
        t_w1c();
        t_chain();
        t_own();
        t_err();
        t_trunc();
        t_endian();
        t_stop();
        t_pause();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule